// File: doc/BRIEF.md
# Main-clock stop detector with low-speed fallback

This block watches a main oscillator clock from the domain of an always-running low-speed reference clock. It samples the main clock as data through a synchronizer and counts reference cycles during which the sampled level does not change. When the main clock has been stuck at 0 or at 1 for a set number of reference cycles, and detection is enabled, the block sets a sticky stop flag.

While the flag is set, any selection of the main clock is redirected to the low-speed clock. This applies to both the system clock selection and the clock-monitor selection. The software select fields themselves are never rewritten. A PLL selection passes through untouched. The flag can drive a level interrupt and a request to put timer outputs into high impedance, each with its own mask.

Software clears the flag by writing 0 to it. That write is refused while the system select field still names the main clock or the PLL. The glitch-free clock multiplexer that acts on the effective select outputs lies outside this block.

Top module: `clkstop_guard`

## Requirements
- R1: After reset the flag reads 0, the control register reads 0, both select fields read 0, `eff_sys_sel` and `eff_mon_sel` are 0, and `irq` and `hiz_req` are low.
- R2: With detection enabled (control bit 0), a main clock held at 0 sets the flag. The flag is still clear THR-2 reference cycles after the hold begins, and it is set THR+10 cycles after the hold begins (THR defaults to 16).
- R3: A main clock held at 1 sets the flag in the same way as R2.
- R4: With detection disabled, a stuck main clock never sets the flag. Enabling detection while the clock is still stuck sets the flag within THR+10 cycles.
- R5: The flag is sticky. It stays set after the main clock resumes toggling.
- R6: The system select field is at address 2, in bits [2:0]. Its encodings are 0 = low-speed, 2 = main, 4 = PLL. While the flag is set and the field is 2, `eff_sys_sel` is 0. With the flag clear, `eff_sys_sel` equals the field. Detection never changes the value read back from the field.
- R7: With the flag set and the field at 4 (PLL), `eff_sys_sel` stays 4.
- R8: The encodings 1, 3, 5, 6 and 7 pass to `eff_sys_sel` unchanged, whatever the flag.
- R9: The flag is at address 1, bit 0. Writing 0 there clears it only when the system field is neither 2 nor 4; otherwise the write is ignored. Writing 1 never sets it.
- R10: `irq` equals flag AND control bit 1. `hiz_req` equals flag AND control bit 2. The control register is at address 0.
- R11: The monitor select field is at address 3, in bits [1:0], where 0 = low-speed and 1 = main. While the flag is set, a monitor value of 1 gives `eff_mon_sel` = 0. All other values pass through unchanged.
- R12: Any change of the main clock restarts the timeout. A main clock that toggles every 4 reference cycles never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Low-speed reference clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_clk | input | 1 | Main oscillator clock, sampled as data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| eff_sys_sel | output | 3 | Effective system clock source select |
| eff_mon_sel | output | 2 | Effective clock-monitor source select |
| irq | output | 1 | Stop interrupt request, level-high |
| hiz_req | output | 1 | Request to force timer outputs to high impedance |

## Verification
The hardest state to reach is the clear interlock while the flag is set. The flag has to be set by a real timeout, and clearing it must not re-arm detection immediately. The bench first stops the main clock to set the flag and then restarts it, so the counter stays far below its threshold. With the flag held, it sweeps every system select encoding and checks both the effective output and whether a clear write takes effect. Only after that sweep does it move the field to a safe source and clear the flag.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  localparam logic [2:0] SRC_LOCO = 3'd0;
  localparam logic [2:0] SRC_MAIN = 3'd2;
  localparam logic [2:0] SRC_PLL  = 3'd4;

  localparam logic [1:0] MON_LOCO = 2'd0;
  localparam logic [1:0] MON_MAIN = 2'd1;

  localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [AW-1:0] ADDR_STAT = 2'd1;
  localparam logic [AW-1:0] ADDR_SYS  = 2'd2;
  localparam logic [AW-1:0] ADDR_MON  = 2'd3;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_IRQ = 1;
  localparam int CTRL_HIZ = 2;

  typedef struct packed {
    logic hiz_en;
    logic irq_en;
    logic det_en;
  } ctrl_t;

  function automatic logic clear_locked(input logic [2:0] s);
    return (s == SRC_MAIN) || (s == SRC_PLL);
  endfunction
endpackage

// File: rtl/clkstop_sync_edge.sv
module clkstop_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic change
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LEN-2:0], lvl_in};
  end

  assign change = chain[LEN-1] ^ chain[LEN-2];
endmodule

// File: rtl/clkstop_timeout.sv
module clkstop_timeout #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !en)   cnt <= '0;
    else if (cnt != LIM)       cnt <= cnt + 1'b1;
  end

  assign expired = en && (cnt == LIM);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);
  assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && en && !restart) |=> (cnt == LIM));
  assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired);
endmodule

// File: rtl/clkstop_regs.sv
module clkstop_regs
  import clkstop_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          stop_hit,
  output ctrl_t         ctrl,
  output logic          flag,
  output logic [2:0]    sys_sel,
  output logic [1:0]    mon_sel
);
  logic wr_ctrl, wr_stat, wr_sys, wr_mon, clr_ok;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_stat = wr_en && (wr_addr == ADDR_STAT);
  assign wr_sys  = wr_en && (wr_addr == ADDR_SYS);
  assign wr_mon  = wr_en && (wr_addr == ADDR_MON);
  assign clr_ok  = wr_stat && !wr_data[0] && !clear_locked(sys_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      sys_sel <= SRC_LOCO;
      mon_sel <= MON_LOCO;
    end else begin
      if (wr_ctrl) ctrl <= '{hiz_en: wr_data[CTRL_HIZ], irq_en: wr_data[CTRL_IRQ],
                             det_en: wr_data[CTRL_EN]};
      if (wr_sys)  sys_sel <= wr_data[2:0];
      if (wr_mon)  mon_sel <= wr_data[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (stop_hit) flag <= 1'b1;
    else if (clr_ok)   flag <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADDR_CTRL: rd_data[2:0] = {ctrl.hiz_en, ctrl.irq_en, ctrl.det_en};
      ADDR_STAT: rd_data[0]   = flag;
      ADDR_SYS:  rd_data[2:0] = sys_sel;
      ADDR_MON:  rd_data[1:0] = mon_sel;
      default:   rd_data      = '0;
    endcase
  end

  assert_clear_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && clear_locked(sys_sel)) |=> flag);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_stat) |=> flag);
  assert_rise_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(stop_hit));
  assert_field_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_sys) |-> $stable(sys_sel));
endmodule

// File: rtl/clkstop_guard.sv
module clkstop_guard
  import clkstop_pkg::*;
#(
  parameter int THR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          main_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    eff_sys_sel,
  output logic [1:0]    eff_mon_sel,
  output logic          irq,
  output logic          hiz_req
);
  logic       edge_seen, expired, flag;
  ctrl_t      ctrl;
  logic [2:0] sys_sel;
  logic [1:0] mon_sel;

  clkstop_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(ref_clk), .rst_n(rst_n), .lvl_in(main_clk), .change(edge_seen));

  clkstop_timeout #(.LIMIT(THR)) u_tmo (
    .clk(ref_clk), .rst_n(rst_n), .en(ctrl.det_en), .restart(edge_seen),
    .expired(expired));

  clkstop_regs u_regs (
    .clk(ref_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .stop_hit(expired), .ctrl(ctrl), .flag(flag), .sys_sel(sys_sel),
    .mon_sel(mon_sel));

  always_comb begin
    eff_sys_sel = sys_sel;
    if (flag && (sys_sel == SRC_MAIN)) eff_sys_sel = SRC_LOCO;
    eff_mon_sel = mon_sel;
    if (flag && (mon_sel == MON_MAIN)) eff_mon_sel = MON_LOCO;
  end

  assign irq     = flag && ctrl.irq_en;
  assign hiz_req = flag && ctrl.hiz_en;

  assert_no_main_when_stopped_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    flag |-> (eff_sys_sel != SRC_MAIN));
  assert_pll_kept_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (sys_sel == SRC_PLL) |-> (eff_sys_sel == SRC_PLL));
  assert_mon_redirect_R11: assert property (@(posedge ref_clk) disable iff (!rst_n)
    flag |-> (eff_mon_sel != MON_MAIN));
  assert_disabled_quiet_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !ctrl.det_en |=> !$rose(flag));
endmodule

// File: tb/clkstop_guard_bench.sv
`timescale 1ns/1ps
module clkstop_guard_bench;
  localparam int THR = 16;
  localparam int TOG = 4;

  logic ref_clk = 1'b0, rst_n = 1'b0, main_clk = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [2:0] eff_sys_sel;
  logic [1:0] eff_mon_sel;
  logic irq, hiz_req;

  int errors = 0, checks = 0;
  logic run_main = 1'b0, stuck_val = 1'b0;
  int ph = 0;

  clkstop_guard #(.THR(THR)) u_clkstop_guard (
    .ref_clk(ref_clk), .rst_n(rst_n), .main_clk(main_clk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .eff_sys_sel(eff_sys_sel), .eff_mon_sel(eff_mon_sel), .irq(irq),
    .hiz_req(hiz_req));

  always #2.5 ref_clk = ~ref_clk;

  always @(negedge ref_clk) begin
    if (run_main) begin
      if (ph == TOG - 1) begin ph <= 0; main_clk <= ~main_clk; end
      else ph <= ph + 1;
    end else main_clk <= stuck_val;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge ref_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge ref_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #0.5; v = rd_data;
  endtask

  task automatic stop_main(input logic lvl);
    @(negedge ref_clk);
    stuck_val = lvl; run_main = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int v;
    cyc(3); rst_n = 1'b1; cyc(1);
    // R1 reset state
    rd(2'd1, v); chk("R1 flag", v, 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd2, v); chk("R1 sys", v, 0);
    rd(2'd3, v); chk("R1 mon", v, 0);
    chk("R1 eff_sys", eff_sys_sel, 0);
    chk("R1 eff_mon", eff_mon_sel, 0);
    chk("R1 irq/hiz", {irq, hiz_req}, 0);

    // R12 toggling main keeps flag clear
    run_main = 1'b1;
    wr(2'd2, 8'd2); wr(2'd3, 8'd1); wr(2'd0, 8'd7);
    cyc(6 * THR);
    rd(2'd1, v); chk("R12 toggling no flag", v, 0);
    chk("R6 eff follows field when clear", eff_sys_sel, 2);

    // R2 stuck at 0
    stop_main(1'b0);
    cyc(THR - 2);
    rd(2'd1, v); chk("R2 not yet", v, 0);
    cyc(12);
    rd(2'd1, v); chk("R2 stuck0 sets flag", v, 1);
    chk("R6 eff redirected", eff_sys_sel, 0);
    rd(2'd2, v); chk("R6 field untouched", v, 2);
    chk("R11 mon redirected", eff_mon_sel, 0);
    chk("R10 irq", irq, 1);
    chk("R10 hiz", hiz_req, 1);

    // R5 sticky after restart
    run_main = 1'b1;
    cyc(4 * THR);
    rd(2'd1, v); chk("R5 sticky", v, 1);

    // R9 clear refused for main and pll; sweep all encodings with flag set
    for (int s = 0; s < 8; s++) begin
      wr(2'd2, 8'(s));
      chk($sformatf("R8 eff with flag s=%0d", s), eff_sys_sel, (s == 2) ? 0 : s);
      if (s == 2 || s == 4) begin
        wr(2'd1, 8'd0);
        rd(2'd1, v); chk($sformatf("R9 clear locked s=%0d", s), v, 1);
        if (s == 4) chk("R7 pll kept", eff_sys_sel, 4);
      end
    end
    for (int m = 0; m < 4; m++) begin
      wr(2'd3, 8'(m));
      chk($sformatf("R11 mon flag m=%0d", m), eff_mon_sel, (m == 1) ? 0 : m);
    end

    // R9 clear allowed on safe source; writing 1 does nothing
    wr(2'd2, 8'd0);
    wr(2'd1, 8'd0);
    rd(2'd1, v); chk("R9 clear accepted", v, 0);
    wr(2'd1, 8'd1);
    rd(2'd1, v); chk("R9 write 1 no set", v, 0);
    chk("R10 irq low after clear", irq, 0);
    for (int s = 0; s < 8; s++) begin
      wr(2'd2, 8'(s));
      chk($sformatf("R8 eff no flag s=%0d", s), eff_sys_sel, s);
    end
    for (int m = 0; m < 4; m++) begin
      wr(2'd3, 8'(m));
      chk($sformatf("R11 mon no flag m=%0d", m), eff_mon_sel, m);
    end

    // R3 stuck at 1, irq/hiz masked
    wr(2'd2, 8'd2);
    wr(2'd0, 8'd1);
    stop_main(1'b1);
    cyc(THR - 2);
    rd(2'd1, v); chk("R3 not yet", v, 0);
    cyc(12);
    rd(2'd1, v); chk("R3 stuck1 sets flag", v, 1);
    for (int c = 0; c < 4; c++) begin
      wr(2'd0, 8'(c << 1));
      chk($sformatf("R10 irq c=%0d", c), irq, c & 1);
      chk($sformatf("R10 hiz c=%0d", c), hiz_req, (c >> 1) & 1);
    end

    // R4 disabled: no detection; enabling while stuck detects
    run_main = 1'b1;
    cyc(10);
    wr(2'd2, 8'd0);
    wr(2'd1, 8'd0);
    rd(2'd1, v); chk("R4 cleared before test", v, 0);
    wr(2'd0, 8'd0);
    stop_main(1'b0);
    cyc(4 * THR);
    rd(2'd1, v); chk("R4 disabled no flag", v, 0);
    wr(2'd0, 8'd1);
    cyc(THR + 10);
    rd(2'd1, v); chk("R4 enable while stuck", v, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule